// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block decides where a 64-bit core with 32-bit instructions fetches next after a control-transfer instruction. Each request carries the decoded operation code, the current PC, an integer operand, a floating operand, a 21-bit word displacement, a jump base value, a link destination index, and two mode flags: privileged mode and floating-point enable. The unit evaluates the condition, forms the target, and requests a link-register write where one is needed. One cycle after the request, it presents all of these results together with a one-cycle valid pulse.

Conditional branches cover signed tests of the integer operand against zero, tests of the operand's bit 0, and zero tests of an IEEE double. Floating branches are refused when floating point is disabled. A refused floating branch or an unknown operation code leaves the PC where it was and signals a trap or an illegal operation. A register jump takes its target from the base value and marks privileged execution in bit 0 of the new PC.

Top module: `branch_resolve`

## Requirements
- R1: After reset, `next_pc` equals the RESET_PC parameter (default 0), and `res_vld`, `taken`, `link_we`, `fp_trap` and `illegal` are all 0.
- R2: A request sampled with `req_vld`=1 on a rising edge produces its results on the outputs right after that edge, with `res_vld`=1 for exactly that cycle. In any cycle without a result, `taken`, `link_we`, `fp_trap` and `illegal` are 0 and `next_pc` keeps its value.
- R3: Operation codes 0 (unconditional branch) and 1 (branch to subroutine) are always taken. Both request a link write of (PC+4) with bits [1:0] cleared, to index `link_idx`.
- R4: Integer codes treat `int_opnd` as signed 64-bit. Taken when the operand is: equal to zero for 3, less than zero for 4, less than or equal to zero for 5, not equal to zero for 7, greater than or equal to zero for 8, greater than zero for 9.
- R5: Code 2 is taken when bit 0 of `int_opnd` is 0, and code 6 is taken when that bit is 1. No other operand bit matters.
- R6: A taken branch goes to PC + 4 + (sign-extended `disp` << 2). A branch that is not taken goes to PC + 4. Only codes 0, 1 and 16 request a link write.
- R7: With `fp_en`=1, codes 10 through 15 apply the tests equal, less, less-or-equal, not-equal, greater-or-equal and greater, in that order, to `fp_opnd` as an IEEE double. Both +0 and -0 (bit 63 either value, bits [62:0] zero) count as zero.
- R8: With `fp_en`=0, codes 10 through 15 set `fp_trap`=1. The PC is held (`next_pc` = PC), with `taken`=0 and no link write.
- R9: Code 16 (register jump) is always taken to `jmp_base` with bits [1:0] cleared. Bit 0 of the target is then set when `priv_mode`=1. The jump writes (PC+4) with bits [1:0] cleared to `link_idx`, and the target comes from `jmp_base` alone.
- R10: A link write whose destination index is 31 is suppressed (`link_we`=0), while the branch or jump itself still resolves normally.
- R11: Codes 17 through 31 set `illegal`=1. The PC is held (`next_pc` = PC), with `taken`=0, `link_we`=0 and `fp_trap`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request valid |
| op | input | 5 | Decoded branch or jump code |
| pc | input | 64 | PC of the branch instruction |
| int_opnd | input | 64 | Integer test operand |
| fp_opnd | input | 64 | Floating test operand, IEEE double bits |
| disp | input | 21 | Word displacement, signed |
| jmp_base | input | 64 | Register jump base value |
| link_idx | input | 5 | Link register destination index |
| priv_mode | input | 1 | Privileged mode flag |
| fp_en | input | 1 | Floating point enabled |
| res_vld | output | 1 | Result valid pulse |
| next_pc | output | 64 | Resolved next PC |
| taken | output | 1 | Control flow redirected |
| link_we | output | 1 | Link register write enable |
| link_dst | output | 5 | Link register destination index |
| link_data | output | 64 | Link register write value |
| fp_trap | output | 1 | Floating-point-disabled trap request |
| illegal | output | 1 | Unknown operation code |

## Verification
The checker watches a set of properties on every cycle. Result flags pulse only with `res_vld`, and `fp_trap`, `illegal` and `taken` exclude one another. A link write never targets index 31 and always carries a word-aligned value, and a result that is not taken and not refused moves the PC by exactly four. A trap or an illegal code holds the PC of the request. Which code is taken for which operand, the signed and floating zero cases, sign extension of negative displacements, and privileged marking of jump targets can only be shown by the bench's directed scenarios, which compare against values worked out by hand.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN = 64,
  parameter int DISP_W = 21,
  parameter int RIDX_W = 5,
  parameter int OP_W = 5,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [OP_W-1:0]   op,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   int_opnd,
  input  logic [XLEN-1:0]   fp_opnd,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   jmp_base,
  input  logic [RIDX_W-1:0] link_idx,
  input  logic              priv_mode,
  input  logic              fp_en,
  output logic              res_vld,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_dst,
  output logic [XLEN-1:0]   link_data,
  output logic              fp_trap,
  output logic              illegal
);
  localparam logic [RIDX_W-1:0] ZERO_REG = '1;
  localparam logic [OP_W-1:0] OP_BR  = OP_W'(0),  OP_BSR  = OP_W'(1),
                              OP_BLC = OP_W'(2),  OP_BEQ  = OP_W'(3),
                              OP_BLT = OP_W'(4),  OP_BLE  = OP_W'(5),
                              OP_BLS = OP_W'(6),  OP_BNE  = OP_W'(7),
                              OP_BGE = OP_W'(8),  OP_BGT  = OP_W'(9),
                              OP_FEQ = OP_W'(10), OP_FLT  = OP_W'(11),
                              OP_FLE = OP_W'(12), OP_FNE  = OP_W'(13),
                              OP_FGE = OP_W'(14), OP_FGT  = OP_W'(15),
                              OP_JMP = OP_W'(16);

  logic [XLEN-1:0] seq_pc, br_tgt, jmp_tgt, nxt;
  logic i_zero, i_neg, f_zero, f_neg, f_pos;
  logic cond, known, is_fp, is_jmp, wants_link, trap_c, go;

  assign seq_pc  = pc + XLEN'(4);
  assign br_tgt  = seq_pc + {{(XLEN-DISP_W-2){disp[DISP_W-1]}}, disp, 2'b00};
  assign jmp_tgt = {jmp_base[XLEN-1:2], 1'b0, priv_mode};

  assign i_zero = (int_opnd == '0);
  assign i_neg  = int_opnd[XLEN-1];
  assign f_zero = (fp_opnd[XLEN-2:0] == '0);
  assign f_neg  = fp_opnd[XLEN-1] & ~f_zero;
  assign f_pos  = ~fp_opnd[XLEN-1] & ~f_zero;

  always_comb begin
    known = 1'b1; cond = 1'b0; is_fp = 1'b0; is_jmp = 1'b0; wants_link = 1'b0;
    case (op)
      OP_BR, OP_BSR: begin cond = 1'b1; wants_link = 1'b1; end
      OP_BLC: cond = ~int_opnd[0];
      OP_BLS: cond = int_opnd[0];
      OP_BEQ: cond = i_zero;
      OP_BNE: cond = ~i_zero;
      OP_BLT: cond = i_neg;
      OP_BLE: cond = i_neg | i_zero;
      OP_BGE: cond = ~i_neg;
      OP_BGT: cond = ~i_neg & ~i_zero;
      OP_FEQ: begin is_fp = 1'b1; cond = f_zero; end
      OP_FNE: begin is_fp = 1'b1; cond = ~f_zero; end
      OP_FLT: begin is_fp = 1'b1; cond = f_neg; end
      OP_FLE: begin is_fp = 1'b1; cond = f_neg | f_zero; end
      OP_FGE: begin is_fp = 1'b1; cond = ~f_neg; end
      OP_FGT: begin is_fp = 1'b1; cond = f_pos; end
      OP_JMP: begin is_jmp = 1'b1; cond = 1'b1; wants_link = 1'b1; end
      default: known = 1'b0;
    endcase
  end

  assign trap_c = is_fp & ~fp_en;
  assign go     = known & ~trap_c & cond;
  assign nxt    = (!known || trap_c) ? pc : is_jmp ? jmp_tgt : go ? br_tgt : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      next_pc   <= RESET_PC;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      link_dst  <= '0;
      link_data <= '0;
      fp_trap   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_vld <= req_vld;
      taken   <= req_vld & go;
      link_we <= req_vld & wants_link & (link_idx != ZERO_REG);
      fp_trap <= req_vld & trap_c;
      illegal <= req_vld & ~known;
      if (req_vld) begin
        next_pc   <= nxt;
        link_dst  <= link_idx;
        link_data <= {seq_pc[XLEN-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int XLEN = 64,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc,
  input logic              res_vld,
  input logic [XLEN-1:0]   next_pc,
  input logic              taken,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_dst,
  input logic [XLEN-1:0]   link_data,
  input logic              fp_trap,
  input logic              illegal
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(taken || link_we || fp_trap || illegal));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld && $past(rst_n) |-> $stable(next_pc));
  assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !taken && !fp_trap && !illegal |-> next_pc == $past(pc) + XLEN'(4));
  assert_link_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data[1:0] == 2'b00);
  assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fp_trap |-> !taken && !link_we && !illegal && next_pc == $past(pc));
  assert_no_zero_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_dst != '1);
  assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !taken && !link_we && !fp_trap && next_pc == $past(pc));
endmodule

bind branch_resolve branch_resolve_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .res_vld(res_vld), .next_pc(next_pc),
  .taken(taken), .link_we(link_we), .link_dst(link_dst), .link_data(link_data),
  .fp_trap(fp_trap), .illegal(illegal));

// File: tb/test_branch_resolve.sv
module test_branch_resolve;
  logic clk = 1'b0, rst_n = 1'b0, req_vld = 1'b0;
  logic [4:0] op = '0, link_idx = '0;
  logic [63:0] pc = '0, int_opnd = '0, fp_opnd = '0, jmp_base = '0;
  logic [20:0] disp = '0;
  logic priv_mode = 1'b0, fp_en = 1'b1;
  logic res_vld, taken, link_we, fp_trap, illegal;
  logic [63:0] next_pc, link_data;
  logic [4:0] link_dst;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_resolve i_branch_resolve (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] o, logic [63:0] p, logic [63:0] iv, logic [63:0] fv,
                       logic [20:0] d, logic [63:0] b, logic [4:0] dst, logic pm, logic fe);
    @(negedge clk);
    op = o; pc = p; int_opnd = iv; fp_opnd = fv; disp = d; jmp_base = b;
    link_idx = dst; priv_mode = pm; fp_en = fe; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic cond_br(string tag, logic [4:0] o, logic [63:0] iv, logic [63:0] fv, logic exp_t);
    issue(o, 64'h3000, iv, fv, 21'd8, '0, 5'd4, 1'b0, 1'b1);
    chk({tag, " valid"}, 64'(res_vld), 64'd1);
    chk({tag, " taken"}, 64'(taken), 64'(exp_t));
    chk({tag, " next_pc"}, next_pc, exp_t ? 64'h3024 : 64'h3004);
    chk({tag, " no link"}, 64'(link_we), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 next_pc", next_pc, 64'd0);
    chk("R1 flags", {59'd0, res_vld, taken, link_we, fp_trap, illegal}, 64'd0);
  endtask

  task automatic t_uncond;
    issue(5'd0, 64'h1000, '0, '0, 21'd5, '0, 5'd7, 1'b0, 1'b1);
    chk("R3 br taken", 64'(taken), 64'd1);
    chk("R6 br target", next_pc, 64'h1018);
    chk("R3 br link_we", 64'(link_we), 64'd1);
    chk("R3 br link_data", link_data, 64'h1004);
    chk("R3 br link_dst", 64'(link_dst), 64'd7);
    issue(5'd1, 64'h2000, '0, '0, 21'h1FFFFD, '0, 5'd26, 1'b0, 1'b1);
    chk("R6 bsr negative disp", next_pc, 64'h1FF8);
    chk("R3 bsr link_data", link_data, 64'h2004);
    issue(5'd1, 64'h2001, '0, '0, 21'd0, '0, 5'd26, 1'b1, 1'b1);
    chk("R3 link low bits cleared", link_data, 64'h2004);
  endtask

  task automatic t_zero_dst;
    issue(5'd0, 64'h1000, '0, '0, 21'd1, '0, 5'd31, 1'b0, 1'b1);
    chk("R10 br dst31 no write", 64'(link_we), 64'd0);
    chk("R10 br dst31 still taken", next_pc, 64'h1008);
    issue(5'd16, 64'h1000, '0, '0, '0, 64'h8000, 5'd31, 1'b0, 1'b1);
    chk("R10 jmp dst31 no write", 64'(link_we), 64'd0);
    chk("R10 jmp dst31 target", next_pc, 64'h8000);
  endtask

  task automatic t_int;
    cond_br("R4 beq 0", 5'd3, 64'd0, '0, 1'b1);
    cond_br("R4 beq 5", 5'd3, 64'd5, '0, 1'b0);
    cond_br("R4 bne 5", 5'd7, 64'd5, '0, 1'b1);
    cond_br("R4 blt min", 5'd4, 64'h8000_0000_0000_0000, '0, 1'b1);
    cond_br("R4 bgt min", 5'd9, 64'h8000_0000_0000_0000, '0, 1'b0);
    cond_br("R4 ble 0", 5'd5, 64'd0, '0, 1'b1);
    cond_br("R4 bge -1", 5'd8, 64'hFFFF_FFFF_FFFF_FFFF, '0, 1'b0);
    cond_br("R4 bge 0", 5'd8, 64'd0, '0, 1'b1);
    cond_br("R4 bgt 0", 5'd9, 64'd0, '0, 1'b0);
  endtask

  task automatic t_lowbit;
    cond_br("R5 blbc even", 5'd2, 64'hFFFF_FFFF_FFFF_FFFE, '0, 1'b1);
    cond_br("R5 blbc odd", 5'd2, 64'd1, '0, 1'b0);
    cond_br("R5 blbs even", 5'd6, 64'd2, '0, 1'b0);
    cond_br("R5 blbs odd", 5'd6, 64'd3, '0, 1'b1);
  endtask

  task automatic t_fp;
    cond_br("R7 fbeq -0", 5'd10, '0, 64'h8000_0000_0000_0000, 1'b1);
    cond_br("R7 fbeq +0", 5'd10, '0, 64'd0, 1'b1);
    cond_br("R7 fblt -0", 5'd11, '0, 64'h8000_0000_0000_0000, 1'b0);
    cond_br("R7 fblt -1.0", 5'd11, '0, 64'hBFF0_0000_0000_0000, 1'b1);
    cond_br("R7 fble -0", 5'd12, '0, 64'h8000_0000_0000_0000, 1'b1);
    cond_br("R7 fbne +1.0", 5'd13, '0, 64'h3FF0_0000_0000_0000, 1'b1);
    cond_br("R7 fbge -0", 5'd14, '0, 64'h8000_0000_0000_0000, 1'b1);
    cond_br("R7 fbgt +1.0", 5'd15, '0, 64'h3FF0_0000_0000_0000, 1'b1);
    cond_br("R7 fbgt +0", 5'd15, '0, 64'd0, 1'b0);
  endtask

  task automatic t_fp_off;
    issue(5'd10, 64'h5000, '0, 64'd0, 21'd8, '0, 5'd4, 1'b0, 1'b0);
    chk("R8 trap", 64'(fp_trap), 64'd1);
    chk("R8 pc held", next_pc, 64'h5000);
    chk("R8 not taken", 64'(taken), 64'd0);
    issue(5'd3, 64'h5000, 64'd0, '0, 21'd8, '0, 5'd4, 1'b0, 1'b0);
    chk("R8 int branch unaffected", 64'(fp_trap), 64'd0);
    chk("R8 int branch target", next_pc, 64'h5024);
  endtask

  task automatic t_jump;
    issue(5'd16, 64'h1000, '0, '0, 21'h155, 64'h4007, 5'd26, 1'b0, 1'b1);
    chk("R9 jmp target", next_pc, 64'h4004);
    chk("R9 jmp taken", 64'(taken), 64'd1);
    chk("R9 jmp link", link_data, 64'h1004);
    chk("R9 jmp link_we", 64'(link_we), 64'd1);
    issue(5'd16, 64'h1000, '0, '0, '0, 64'h4006, 5'd26, 1'b1, 1'b1);
    chk("R9 jmp priv bit0", next_pc, 64'h4005);
  endtask

  task automatic t_illegal;
    issue(5'd20, 64'h6000, '0, '0, 21'd8, '0, 5'd4, 1'b0, 1'b1);
    chk("R11 illegal flag", 64'(illegal), 64'd1);
    chk("R11 pc held", next_pc, 64'h6000);
    chk("R11 no link/taken", {62'd0, taken, link_we}, 64'd0);
  endtask

  task automatic t_idle;
    issue(5'd0, 64'h7000, '0, '0, 21'd1, '0, 5'd3, 1'b0, 1'b1);
    @(negedge clk);
    chk("R2 valid drops", 64'(res_vld), 64'd0);
    chk("R2 flags drop", {62'd0, taken, link_we}, 64'd0);
    chk("R2 next_pc held", next_pc, 64'h7008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_uncond();
    t_zero_dst();
    t_int();
    t_lowbit();
    t_fp();
    t_fp_off();
    t_jump();
    t_illegal();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule